// File: doc/BRIEF.md
# Indexed Effective Address Generator

This block forms the 8-bit address that a small 4-bit processor presents to its single memory, which holds both program and data. Two 4-bit address registers, a high part and a low part, are joined into a base address. The top bit of that base, which is bit 3 of the high part, chooses the addressing mode. When it is clear, the base passes through as the address (direct mode). When it is set, the zero-extended 4-bit index register B is added to the base (indexed mode).

The adder is always in the path. A 2-to-1 selector feeds it either zero or the index value, so the two modes share one datapath and differ only in the addend. The sum keeps the low 8 bits. It wraps at 256, and bit 7 of the base stays part of the sum. A copy of the result is also loaded into an output register when the address-load enable is high. Memory, the loading of the address registers and the rest of the datapath are outside this block.

Top module: `eff_addr_gen`

## Requirements
- R1: With bit 3 of `addr_hi_i` at 0, `ea_o` equals `{addr_hi_i, addr_lo_i}` in the same cycle.
- R2: With bit 3 of `addr_hi_i` at 1, `ea_o` equals `{addr_hi_i, addr_lo_i} + {4'h0, idx_b_i}`, kept to 8 bits, in the same cycle.
- R3: In direct mode the value of `idx_b_i` has no effect on `ea_o`.
- R4: A carry out of bit 7 is dropped, so the address wraps modulo 256 (for example 0xFF + 0xF gives 0x0E, and 0xF8 + 0x8 gives 0x00).
- R5: Bit 7 of the base is not masked in indexed mode (for example base 0x80 with index 5 gives 0x85).
- R6: `idx_mode_o` is 1 exactly when bit 3 of `addr_hi_i` is 1.
- R7: On a rising clock edge with `ld_en_i` high, `ea_q_o` takes the value `ea_o` had before that edge.
- R8: On a rising clock edge with `ld_en_i` low, `ea_q_o` keeps its value.
- R9: While `rst_ni` is low, `ea_q_o` is 0x00, and it clears as soon as `rst_ni` falls, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_hi_i | input | 4 | High address part; its bit 3 selects the mode |
| addr_lo_i | input | 4 | Low address part |
| idx_b_i | input | 4 | Index register B |
| ld_en_i | input | 1 | Address-load enable for the output register |
| ea_o | output | 8 | Combinational effective address |
| ea_q_o | output | 8 | Registered effective address |
| idx_mode_o | output | 1 | 1 when indexed mode is active |

## Verification
The indexed add and the register load can fall in the same cycle. The harshest case is when that add also wraps past 0xFF. The bench sets up a wrapping indexed address with the load enable high, and after the edge it compares the registered output with the wrapped sum worked out from R2 and R4. It then changes the inputs with the enable low to confirm that the register holds its value while the combinational output moves.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic {
    EA_DIRECT  = 1'b0,
    EA_INDEXED = 1'b1
  } ea_mode_e;
endpackage

// File: rtl/ea_index_mux.sv
module ea_index_mux
  import ea_pkg::*;
#(
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned ADDR_W = 8
) (
  input  ea_mode_e           mode_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [ADDR_W-1:0]  addend_o
);
  logic [ADDR_W-1:0] idx_ext;

  generate
    if (IDX_W >= ADDR_W) begin : g_trunc
      assign idx_ext = idx_i[ADDR_W-1:0];
    end else begin : g_zext
      assign idx_ext = {{(ADDR_W-IDX_W){1'b0}}, idx_i};
    end
  endgenerate

  always_comb begin
    addend_o = '0;
    if (mode_i == EA_INDEXED) addend_o = idx_ext;
  end
endmodule

// File: rtl/ea_ripple_adder.sv
module ea_ripple_adder #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);
  // carry out of the top bit is not formed: result wraps modulo 2**W
  logic [W-1:0] cin;
  assign cin[0] = 1'b0;

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      logic p;
      assign p        = a_i[i] ^ b_i[i];
      assign sum_o[i] = p ^ cin[i];
      if (i < W - 1) begin : g_carry
        assign cin[i+1] = (a_i[i] & b_i[i]) | (cin[i] & p);
      end
    end
  endgenerate
endmodule

// File: rtl/ea_out_reg.sv
module ea_out_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (ld_en_i) q_o <= d_i;
  end
endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen
  import ea_pkg::*;
#(
  parameter int unsigned NIB_W = 4,
  parameter int unsigned IDX_W = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NIB_W-1:0]     addr_hi_i,
  input  logic [NIB_W-1:0]     addr_lo_i,
  input  logic [IDX_W-1:0]     idx_b_i,
  input  logic                 ld_en_i,
  output logic [2*NIB_W-1:0]   ea_o,
  output logic [2*NIB_W-1:0]   ea_q_o,
  output logic                 idx_mode_o
);
  localparam int unsigned ADDR_W = 2 * NIB_W;

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] addend;
  ea_mode_e          mode;

  assign base       = {addr_hi_i, addr_lo_i};
  // mode bit lives inside the address and stays in the sum
  assign mode       = ea_mode_e'(base[ADDR_W-1]);
  assign idx_mode_o = (mode == EA_INDEXED);

  ea_index_mux #(
    .IDX_W  (IDX_W),
    .ADDR_W (ADDR_W)
  ) u_mux (
    .mode_i   (mode),
    .idx_i    (idx_b_i),
    .addend_o (addend)
  );

  ea_ripple_adder #(
    .W (ADDR_W)
  ) u_add (
    .a_i   (base),
    .b_i   (addend),
    .sum_o (ea_o)
  );

  ea_out_reg #(
    .W (ADDR_W)
  ) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ld_en_i (ld_en_i),
    .d_i     (ea_o),
    .q_o     (ea_q_o)
  );
endmodule

// File: rtl/eff_addr_gen_chk.sv
module eff_addr_gen_chk #(
  parameter int unsigned NIB_W = 4,
  parameter int unsigned IDX_W = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NIB_W-1:0]     addr_hi_i,
  input logic [NIB_W-1:0]     addr_lo_i,
  input logic [IDX_W-1:0]     idx_b_i,
  input logic                 ld_en_i,
  input logic [2*NIB_W-1:0]   ea_o,
  input logic [2*NIB_W-1:0]   ea_q_o,
  input logic                 idx_mode_o
);
  localparam int unsigned ADDR_W = 2 * NIB_W;

  logic [ADDR_W-1:0] base_c;
  logic [ADDR_W:0]   wide_sum_c;
  assign base_c     = {addr_hi_i, addr_lo_i};
  assign wide_sum_c = {1'b0, base_c} + (ADDR_W+1)'(idx_b_i);

  AST_DIRECT_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_hi_i[NIB_W-1] |-> ea_o == base_c); // R1

  AST_INDEX_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_hi_i[NIB_W-1] |-> ea_o == wide_sum_c[ADDR_W-1:0]); // R2

  AST_WRAP_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_hi_i[NIB_W-1] && wide_sum_c[ADDR_W]) |-> ea_o < base_c); // R4

  AST_MODE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_mode_o == addr_hi_i[NIB_W-1]); // R6

  AST_LOAD_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_en_i |=> ea_q_o == $past(ea_o)); // R7

  AST_LOAD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_en_i |=> $stable(ea_q_o)); // R8
endmodule

bind eff_addr_gen eff_addr_gen_chk #(
  .NIB_W (NIB_W),
  .IDX_W (IDX_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_hi_i  (addr_hi_i),
  .addr_lo_i  (addr_lo_i),
  .idx_b_i    (idx_b_i),
  .ld_en_i    (ld_en_i),
  .ea_o       (ea_o),
  .ea_q_o     (ea_q_o),
  .idx_mode_o (idx_mode_o)
);

// File: tb/eff_addr_gen_tb.sv
module eff_addr_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  // {hi, lo, b, expected ea}
  localparam logic [19:0] VEC [NVEC] = '{
    {4'h3, 4'hC, 4'h9, 8'h3C},  // R1 R3 direct, B ignored
    {4'h7, 4'hF, 4'hF, 8'h7F},  // R1 R3 top of direct half
    {4'h0, 4'h0, 4'h5, 8'h00},  // R1 R3
    {4'h8, 4'h0, 4'h5, 8'h85},  // R2 R5 bit 7 kept
    {4'h9, 4'hA, 4'h3, 8'h9D},  // R2
    {4'hF, 4'hF, 4'hF, 8'h0E},  // R4 wrap
    {4'hF, 4'h8, 4'h8, 8'h00},  // R4 wrap to zero
    {4'hC, 4'h4, 4'h0, 8'hC4},  // R2 zero index
    {4'hA, 4'hF, 4'h1, 8'hB0},  // R2 carry into high nibble
    {4'hE, 4'h7, 4'hF, 8'hF6}   // R2 R5
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] addr_hi_i = '0;
  logic [3:0] addr_lo_i = '0;
  logic [3:0] idx_b_i = '0;
  logic       ld_en_i = 1'b0;
  logic [7:0] ea_o;
  logic [7:0] ea_q_o;
  logic       idx_mode_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  eff_addr_gen u_dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_hi_i  (addr_hi_i),
    .addr_lo_i  (addr_lo_i),
    .idx_b_i    (idx_b_i),
    .ld_en_i    (ld_en_i),
    .ea_o       (ea_o),
    .ea_q_o     (ea_q_o),
    .idx_mode_o (idx_mode_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] hi, input logic [3:0] lo, input logic [3:0] b, input logic ld);
    addr_hi_i = hi;
    addr_lo_i = lo;
    idx_b_i   = b;
    ld_en_i   = ld;
  endtask

  initial begin
    #(CLK_PERIOD * 2000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    #1 chk("R9 reset value", ea_q_o, 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk_i);
      drive(VEC[i][19:16], VEC[i][15:12], VEC[i][11:8], 1'b0);
      #1;
      chk($sformatf("R1/R2/R3/R4/R5 vec %0d", i), ea_o, VEC[i][7:0]);
      chk($sformatf("R6 vec %0d", i), {7'b0, idx_mode_o}, {7'b0, VEC[i][19]});
    end

    // R3: sweep B in direct mode, address must not move
    for (int b = 0; b < 16; b++) begin
      @(negedge clk_i);
      drive(4'h5, 4'hA, 4'(b), 1'b0);
      #1 chk("R3 B sweep", ea_o, 8'h5A);
    end

    // R7 with R4: load a wrapping indexed address
    @(negedge clk_i);
    drive(4'hF, 4'hF, 4'hF, 1'b1);
    @(negedge clk_i);
    #1 chk("R7 R4 load wrapped", ea_q_o, 8'h0E);

    // R8: enable low, inputs change, register holds
    drive(4'h1, 4'h2, 4'h3, 1'b0);
    @(negedge clk_i);
    #1 chk("R8 hold", ea_q_o, 8'h0E);
    chk("R1 comb moves", ea_o, 8'h12);

    // R7 with R5
    drive(4'h8, 4'h0, 4'h0, 1'b1);
    @(negedge clk_i);
    #1 chk("R7 R5 load", ea_q_o, 8'h80);
    ld_en_i = 1'b0;

    // R9: async clear mid-cycle
    #2 rst_ni = 1'b0;
    #1 chk("R9 async clear", ea_q_o, 8'h00);
    @(negedge clk_i);
    ld_en_i = 1'b1;
    @(negedge clk_i);
    #1 chk("R9 held in reset", ea_q_o, 8'h00);
    rst_ni = 1'b1;
    drive(4'h9, 4'h0, 4'h7, 1'b1);
    @(negedge clk_i);
    #1 chk("R7 R2 load after reset", ea_q_o, 8'h97);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule